// File: doc/BRIEF.md
# Receive Descriptor Status Writeback Engine

This block closes the host buffers that a network receiver fills. The receive path reports how a frame is progressing: its start, a full buffer, its end, an FCS failure, leftover bits that do not make up a whole byte, a receive-error strobe from the MII, FIFO overflow and bus parity trouble. From these the engine builds one status word per buffer and hands that buffer back to the host by writing its ownership bit as 0.

A frame that does not fit in one buffer has to be chained into the next descriptor. When a buffer fills, the engine asks for the next descriptor's ownership bit and holds back the writeback of the full buffer until that bit arrives. This means no descriptor is ever written after ownership has gone to the host. If the next buffer is not available, or the FIFO overflows while the engine waits, the current buffer is closed as the end of a broken frame and the rest of the frame is discarded.

The controller has four states. IDLE waits for a frame to start. FILL collects events while a buffer is being filled. FETCH waits for the next descriptor's ownership bit. DROP discards the rest of a broken frame. The transitions are:
- IDLE→FILL on frame start.
- FILL→IDLE on frame end, with the final writeback.
- FILL→FETCH on buffer full.
- FETCH→FILL when the ownership response is 1, with the intermediate writeback.
- FETCH→DROP when the response is 0 or the FIFO overflows, with the buffer-error writeback.
- DROP→IDLE on frame end.

Top module: `rx_desc_wb`

## Requirements
- R1: Every writeback (`wb_valid` high for one cycle, in the cycle after the event that closes the buffer) has the ownership bit `wb_status[8]` at 0. Each closed buffer gets exactly one writeback. Status layout: [8] own, [7] err, [6] fram, [5] oflo, [4] crc, [3] buff, [2] bpe, [1] stp, [0] enp.
- R2: The first buffer of a frame has stp=1 and every later buffer has stp=0. Only the buffer that ends the frame (or a broken frame) has enp=1. A frame that fits in one buffer has both bits set.
- R3: err equals the OR of fram, oflo, crc, buff and bpe. bpe is sticky for the whole frame and is reported on every buffer of that frame.
- R4: fram is 1 only when the frame had leftover bits and also an FCS error. Leftover bits with a good FCS give fram=0 and crc=0.
- R5: crc and fram can be 1 only on an enp=1 descriptor with oflo=0. An overflow during filling followed by frame end gives oflo=1 with crc=0 and fram=0.
- R6: A receive-error strobe during the frame sets crc on its final descriptor. It never sets fram, even when leftover bits are present.
- R7: On buffer full, `own_req` goes high and stays high until an ownership response or an overflow. A response of 1 writes the full buffer with enp=0, and chaining continues in a new buffer.
- R8: A response of 0 closes the current buffer with buff=1, enp=1 and oflo=0, even if the frame overflowed earlier. After that, no writeback occurs until a new frame starts after the frame end.
- R9: A FIFO overflow while the ownership response is pending closes the current buffer with buff=1, oflo=1 and enp=1. If both arrive in the same cycle, the overflow takes priority over the response.
- R10: While `loopback_en` is high, fram is written as 0.
- R11: Frame end and buffer full in the same cycle end the frame in that buffer, and no ownership request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loopback_en | input | 1 | Internal loopback mode enabled |
| evt_sof | input | 1 | Frame start strobe |
| evt_buf_full | input | 1 | Current buffer full strobe |
| evt_eof | input | 1 | Frame end strobe |
| evt_fcs_err | input | 1 | FCS check failed |
| evt_dribble | input | 1 | Frame length not a whole number of bytes |
| evt_rx_er | input | 1 | Receive-error strobe from the MII |
| evt_fifo_ovf | input | 1 | Receive FIFO overflow |
| evt_bus_perr | input | 1 | Bus parity error |
| own_req | output | 1 | Request for the next descriptor's ownership bit |
| own_rsp_valid | input | 1 | Ownership response valid |
| own_rsp_bit | input | 1 | Fetched ownership bit (1 = receiver owns) |
| wb_valid | output | 1 | Status writeback strobe |
| wb_status | output | 9 | Status word written to the descriptor |

## Verification
The assertions assume a well-formed event stream:
- A frame start arrives only while the engine is idle.
- Frame end never arrives while an ownership request is pending.
- An ownership response arrives only while `own_req` is high.

The stimulus follows these rules by construction. Each scenario is driven as a complete frame, a response is sent only after the request has been observed, and no frame end is issued until the request has been answered. Within those rules the scenarios cover the event orderings that matter for the status bits: same-cycle collisions, overflow before and during the fetch wait, and delayed responses.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;

    localparam int N_FLAGS = 5;
    localparam int FL_FCS  = 0;
    localparam int FL_DRIB = 1;
    localparam int FL_RXER = 2;
    localparam int FL_OVF  = 3;
    localparam int FL_BPE  = 4;

    typedef struct packed {
        logic own;
        logic err;
        logic fram;
        logic oflo;
        logic crc;
        logic buff;
        logic bpe;
        logic stp;
        logic enp;
    } rxwb_status_t;

    localparam int STATUS_W = $bits(rxwb_status_t);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_FETCH,
        ST_DROP
    } rxwb_state_t;

    typedef enum logic [1:0] {
        CL_END,
        CL_MID,
        CL_NOBUF,
        CL_OVFWAIT
    } rxwb_close_t;

endpackage

// File: rtl/rxwb_accum.sv
module rxwb_accum #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] evt,
    output logic [W-1:0] view
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) q <= '0;
        else if (en)       q <= q | evt;
    end

    // sticky flags including the events of the current cycle
    assign view = en ? (q | evt) : q;
endmodule

// File: rtl/rxwb_compose.sv
module rxwb_compose
    import rxwb_pkg::*;
(
    input  logic [N_FLAGS-1:0] flags,
    input  rxwb_close_t        kind,
    input  logic               stp,
    input  logic               loopback,
    output rxwb_status_t       status
);
    always_comb begin
        status      = '0;
        status.own  = 1'b0;
        status.stp  = stp;
        status.bpe  = flags[FL_BPE];
        unique case (kind)
            CL_END: begin
                status.enp  = 1'b1;
                status.oflo = flags[FL_OVF];
                status.crc  = !flags[FL_OVF] && (flags[FL_FCS] || flags[FL_RXER]);
                status.fram = !flags[FL_OVF] && !loopback
                              && flags[FL_DRIB] && flags[FL_FCS];
            end
            CL_MID: status.enp = 1'b0;
            CL_NOBUF: begin
                status.enp  = 1'b1;
                status.buff = 1'b1;
            end
            CL_OVFWAIT: begin
                status.enp  = 1'b1;
                status.buff = 1'b1;
                status.oflo = 1'b1;
            end
            default: status.enp = 1'b0;
        endcase
        status.err = status.fram | status.oflo | status.crc | status.buff | status.bpe;
    end
endmodule

// File: rtl/rx_desc_wb.sv
module rx_desc_wb
    import rxwb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                loopback_en,
    input  logic                evt_sof,
    input  logic                evt_buf_full,
    input  logic                evt_eof,
    input  logic                evt_fcs_err,
    input  logic                evt_dribble,
    input  logic                evt_rx_er,
    input  logic                evt_fifo_ovf,
    input  logic                evt_bus_perr,
    output logic                own_req,
    input  logic                own_rsp_valid,
    input  logic                own_rsp_bit,
    output logic                wb_valid,
    output logic [STATUS_W-1:0] wb_status
);
    rxwb_state_t  st_q, st_d;
    rxwb_close_t  close_kind;
    logic         close_fire;
    logic         acc_clr, acc_en;
    logic         stp_q;
    logic [N_FLAGS-1:0] evt_vec, flags;
    rxwb_status_t composed;

    always_comb begin
        evt_vec          = '0;
        evt_vec[FL_FCS]  = evt_fcs_err;
        evt_vec[FL_DRIB] = evt_dribble;
        evt_vec[FL_RXER] = evt_rx_er;
        evt_vec[FL_OVF]  = evt_fifo_ovf;
        evt_vec[FL_BPE]  = evt_bus_perr;
    end

    assign acc_clr = (st_q == ST_IDLE) && evt_sof;
    assign acc_en  = (st_q == ST_FILL) || (st_q == ST_FETCH);

    rxwb_accum #(.W(N_FLAGS)) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .en    (acc_en),
        .evt   (evt_vec),
        .view  (flags)
    );

    rxwb_compose u_compose (
        .flags    (flags),
        .kind     (close_kind),
        .stp      (stp_q),
        .loopback (loopback_en),
        .status   (composed)
    );

    // next state and close decision
    always_comb begin
        st_d       = st_q;
        close_fire = 1'b0;
        close_kind = CL_MID;
        unique case (st_q)
            ST_IDLE:  if (evt_sof) st_d = ST_FILL;
            ST_FILL: begin
                if (evt_eof) begin
                    close_fire = 1'b1;
                    close_kind = CL_END;
                    st_d       = ST_IDLE;
                end else if (evt_buf_full) begin
                    st_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (evt_fifo_ovf) begin
                    close_fire = 1'b1;
                    close_kind = CL_OVFWAIT;
                    st_d       = ST_DROP;
                end else if (own_rsp_valid && own_rsp_bit) begin
                    close_fire = 1'b1;
                    close_kind = CL_MID;
                    st_d       = ST_FILL;
                end else if (own_rsp_valid) begin
                    close_fire = 1'b1;
                    close_kind = CL_NOBUF;
                    st_d       = ST_DROP;
                end
            end
            ST_DROP:  if (evt_eof) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // first-buffer marker
    always_ff @(posedge clk) begin
        if (!rst_n)                                 stp_q <= 1'b0;
        else if (acc_clr)                           stp_q <= 1'b1;
        else if (close_fire && close_kind == CL_MID) stp_q <= 1'b0;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid  <= 1'b0;
            wb_status <= '0;
        end else begin
            wb_valid  <= close_fire;
            if (close_fire) wb_status <= composed;
        end
    end

    assign own_req = (st_q == ST_FETCH);
endmodule

// File: rtl/rx_desc_wb_chk.sv
module rx_desc_wb_chk
    import rxwb_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                loopback_en,
    input logic                evt_fifo_ovf,
    input logic                own_req,
    input logic                own_rsp_valid,
    input logic                own_rsp_bit,
    input logic                wb_valid,
    input logic [STATUS_W-1:0] wb_status
);
    rxwb_status_t s;
    assign s = rxwb_status_t'(wb_status);

    AST_OWN_RETURNED: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !s.own); // R1
    AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (s.err == (s.fram | s.oflo | s.crc | s.buff | s.bpe))); // R3
    AST_FRAM_WITH_CRC: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && s.fram) |-> s.crc); // R4
    AST_CRC_ONLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && (s.crc || s.fram)) |-> (s.enp && !s.oflo)); // R5
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (own_req && !own_rsp_valid && !evt_fifo_ovf) |=> own_req); // R7
    AST_CHAIN_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (own_req && own_rsp_valid && own_rsp_bit && !evt_fifo_ovf) |=> (wb_valid && !s.enp)); // R7
    AST_BUFF_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && s.buff) |-> s.enp); // R8
    AST_WAIT_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (own_req && evt_fifo_ovf) |=> (wb_valid && s.buff && s.oflo)); // R9
    AST_LOOPBACK_NOFRAM: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && $past(loopback_en)) |-> !s.fram); // R10
endmodule

bind rx_desc_wb rx_desc_wb_chk u_chk (.*);

// File: tb/sim_rx_desc_wb.sv
module sim_rx_desc_wb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic loopback_en = 1'b0;
    logic evt_sof = 0, evt_buf_full = 0, evt_eof = 0, evt_fcs_err = 0;
    logic evt_dribble = 0, evt_rx_er = 0, evt_fifo_ovf = 0, evt_bus_perr = 0;
    logic own_rsp_valid = 0, own_rsp_bit = 0;
    logic own_req, wb_valid;
    logic [8:0] wb_status;

    always #4 clk = ~clk; // 125 MHz

    rx_desc_wb u0 (.*);

    localparam logic [7:0] S = 8'h80, BF = 8'h40, EO = 8'h20, FC = 8'h10,
                           DR = 8'h08, RE = 8'h04, OV = 8'h02, BP = 8'h01;

    int total = 0, bad = 0, cycles = 0;
    string cur_req = "R1";
    bit done = 0;

    // behavioural reference
    int mode = 0;
    bit m_stp, f_fcs, f_dr, f_re, f_ov, f_bp;
    bit exp_valid = 0;
    logic [8:0] exp_status = '0;
    int wb_seen = 0;

    function automatic logic [8:0] mk(bit fram, bit oflo, bit crc, bit buff,
                                      bit bpe, bit stp, bit enp);
        bit err = fram | oflo | crc | buff | bpe;
        return {1'b0, err, fram, oflo, crc, buff, bpe, stp, enp};
    endfunction

    always @(posedge clk) begin
        exp_valid = 0;
        if (!rst_n) begin
            mode = 0;
        end else begin
            if (mode == 1 || mode == 2) begin
                f_fcs |= evt_fcs_err; f_dr |= evt_dribble; f_re |= evt_rx_er;
                f_ov  |= evt_fifo_ovf; f_bp |= evt_bus_perr;
            end
            case (mode)
                0: if (evt_sof) begin
                    mode = 1; m_stp = 1;
                    {f_fcs, f_dr, f_re, f_ov, f_bp} = '0;
                end
                1: if (evt_eof) begin
                    exp_valid = 1;
                    exp_status = mk(!f_ov && !loopback_en && f_dr && f_fcs, f_ov,
                                    !f_ov && (f_fcs || f_re), 0, f_bp, m_stp, 1);
                    mode = 0;
                end else if (evt_buf_full) mode = 2;
                2: if (evt_fifo_ovf) begin
                    exp_valid = 1; exp_status = mk(0, 1, 0, 1, f_bp, m_stp, 1); mode = 3;
                end else if (own_rsp_valid && own_rsp_bit) begin
                    exp_valid = 1; exp_status = mk(0, 0, 0, 0, f_bp, m_stp, 0);
                    m_stp = 0; mode = 1;
                end else if (own_rsp_valid) begin
                    exp_valid = 1; exp_status = mk(0, 0, 0, 1, f_bp, m_stp, 1); mode = 3;
                end
                3: if (evt_eof) mode = 0;
                default: mode = 0;
            endcase
        end
    end

    // compared on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (wb_valid !== exp_valid || own_req !== (mode == 2) ||
                (exp_valid && wb_status !== exp_status)) begin
                bad++;
                $display("FAIL %s: valid=%b req=%b status=%b expected valid=%b req=%b status=%b",
                         cur_req, wb_valid, own_req, wb_status, exp_valid, mode == 2, exp_status);
            end
            if (wb_valid) wb_seen++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1; bad++; total++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic cyc(input logic [7:0] e, input bit rv = 0, input bit rb = 0);
        @(negedge clk);
        {evt_sof, evt_buf_full, evt_eof, evt_fcs_err, evt_dribble, evt_rx_er,
         evt_fifo_ovf, evt_bus_perr} = e;
        own_rsp_valid = rv; own_rsp_bit = rb;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(8'h00);
    endtask

    task automatic chk_count(input string req, input int exp);
        total++;
        if (wb_seen != exp) begin
            bad++;
            $display("FAIL %s: writebacks=%0d expected=%0d", req, wb_seen, exp);
        end
    endtask

    initial begin
        idle(3);
        total++; // R1 reset state
        if (wb_valid !== 0 || own_req !== 0) begin
            bad++;
            $display("FAIL R1 reset: valid=%b req=%b expected 0 0", wb_valid, own_req);
        end
        @(negedge clk); rst_n = 1;
        idle(2);

        cur_req = "R2"; wb_seen = 0;
        cyc(S); idle(3); cyc(EO); idle(3);
        chk_count("R2", 1);

        cur_req = "R4"; cyc(S); cyc(DR); cyc(FC); cyc(EO); idle(3);
        cyc(S); cyc(DR); idle(2); cyc(EO); idle(3);
        cur_req = "R6"; cyc(S); cyc(RE | DR); cyc(EO); idle(3);
        cur_req = "R10"; loopback_en = 1;
        cyc(S); cyc(FC | DR); cyc(EO); idle(3);
        @(negedge clk); loopback_en = 0;
        cur_req = "R5"; cyc(S); cyc(OV); cyc(FC | DR); cyc(EO); idle(3);
        cur_req = "R3"; cyc(S); cyc(BP); cyc(BF); idle(2); cyc(8'h00, 1, 1); idle(2); cyc(EO); idle(3);

        cur_req = "R7"; wb_seen = 0;
        cyc(S); idle(2); cyc(BF); idle(4); cyc(8'h00, 1, 1);
        idle(2); cyc(BF); cyc(8'h00, 1, 1); idle(2); cyc(FC | EO); idle(3);
        chk_count("R7", 3);

        cur_req = "R8"; wb_seen = 0;
        cyc(S); cyc(OV); cyc(BF); idle(2); cyc(8'h00, 1, 0);
        idle(2); cyc(BF); cyc(FC); cyc(EO); idle(2); cyc(BF | EO); idle(3);
        chk_count("R8", 1);

        cur_req = "R9"; cyc(S); cyc(BF); idle(2); cyc(OV, 1, 1); idle(2); cyc(EO); idle(3);
        cyc(S); cyc(BF); cyc(FC | OV); idle(2); cyc(EO); idle(3);

        cur_req = "R11"; wb_seen = 0;
        cyc(S); cyc(DR); cyc(FC | BF | EO); idle(4);
        chk_count("R11", 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule